// File: doc/BRIEF.md
# Receive Error DMA Request Gating

This block sits between a serial receiver and a DMA controller. It decides whether each received character raises a data-ready flag and a DMA request. The decision depends on the error bits that arrive with the character. The block holds one flag for each error class: parity, framing and noise. It also holds an overrun flag. Each of these flags stays set until its own clear strobe.

A configuration bit selects one of two policies. In skip mode (bit low), a faulty character only records its error and leaves data-ready alone. The next clean character is then delivered by DMA as usual. In hold mode (bit high), a faulty character is latched like any other, but the DMA request stays withheld while any error flag remains set. Software must then read the data or clear the errors.

The policy bit is taken in only while reception is disabled. Characters offered while reception is disabled are ignored.

Top module: `rx_err_dma_gate`

## Requirements
- R1: An accepted character (`rx_en` and `char_valid` both high) with `char_perr`, `char_ferr` or `char_nerr` set sets the matching flag on the next clock edge. This holds even when that flag's clear strobe is high in the same cycle.
- R2: Each error flag and the overrun flag stays set until its own clear strobe. Clear strobes for other flags, and `dr_clear`, leave it unchanged.
- R3: In skip mode, an accepted character with any error bit leaves `data_ready` unchanged and never sets `ovr_flag`.
- R4: In skip mode, an accepted error-free character sets `data_ready` when no held character blocks it.
- R5: In hold mode, an accepted character with error bits sets both `data_ready` and the matching error flags.
- R6: `dma_req` is high exactly when `data_ready` and `dma_en` are high and hold mode does not have any error flag set. It follows `dma_en` within the same cycle.
- R7: `dr_clear` clears `data_ready` on the next edge, unless a character that sets data-ready is accepted in the same cycle. In that case `data_ready` stays 1 and no overrun is raised.
- R8: A character that would set data-ready while `data_ready` is 1 and `dr_clear` is low sets `ovr_flag` instead, and `data_ready` stays 1. `ovr_clear` clears `ovr_flag`.
- R9: The policy input `err_hold_mode` is captured only on edges where `rx_en` is low. Characters presented while `rx_en` is low change no output.
- R10: In hold mode, with `data_ready` still set, clearing the last error flag lets `dma_req` rise in the cycle after the clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception enabled; policy locked while high |
| err_hold_mode | input | 1 | Policy: 0 skip faulty characters, 1 hold them and mask DMA |
| char_valid | input | 1 | Character-received strobe |
| char_perr | input | 1 | Parity error of the character |
| char_ferr | input | 1 | Framing error of the character |
| char_nerr | input | 1 | Noise error of the character |
| dma_en | input | 1 | DMA requests allowed |
| dr_clear | input | 1 | Data-ready clear (data read) |
| perr_clear | input | 1 | Parity flag clear |
| ferr_clear | input | 1 | Framing flag clear |
| nerr_clear | input | 1 | Noise flag clear |
| ovr_clear | input | 1 | Overrun flag clear |
| data_ready | output | 1 | A character is held for reading |
| perr_flag | output | 1 | Sticky parity error |
| ferr_flag | output | 1 | Sticky framing error |
| nerr_flag | output | 1 | Sticky noise error |
| ovr_flag | output | 1 | Sticky overrun |
| dma_req | output | 1 | DMA request line |

## Verification
Two functions can fall in the same cycle:
- an incoming character together with a clear strobe on the flag it sets;
- a new character together with `dr_clear` on a held character.

The bench provokes both on purpose. The random phase also raises the strobes with enough density that such collisions recur in both policies. A behavioural reference model judges each cycle, with a set-wins rule for flags and a read-then-accept rule for data-ready. Directed checks confirm that the flag stays set and that no overrun appears.

// File: rtl/rx_err_dma_gate.sv
module rx_err_dma_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic err_hold_mode,
  input  logic char_valid,
  input  logic char_perr,
  input  logic char_ferr,
  input  logic char_nerr,
  input  logic dma_en,
  input  logic dr_clear,
  input  logic perr_clear,
  input  logic ferr_clear,
  input  logic nerr_clear,
  input  logic ovr_clear,
  output logic data_ready,
  output logic perr_flag,
  output logic ferr_flag,
  output logic nerr_flag,
  output logic ovr_flag,
  output logic dma_req
);

  logic hold_q;
  logic accept, faulty, lands, blocked;

  assign accept  = rx_en & char_valid;
  assign faulty  = char_perr | char_ferr | char_nerr;
  assign lands   = accept & (hold_q | ~faulty);
  assign blocked = data_ready & ~dr_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      data_ready <= 1'b0;
      perr_flag  <= 1'b0;
      ferr_flag  <= 1'b0;
      nerr_flag  <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      if (!rx_en) hold_q <= err_hold_mode;
      data_ready <= lands | blocked;
      perr_flag  <= (accept & char_perr) | (perr_flag & ~perr_clear);
      ferr_flag  <= (accept & char_ferr) | (ferr_flag & ~ferr_clear);
      nerr_flag  <= (accept & char_nerr) | (nerr_flag & ~nerr_clear);
      ovr_flag   <= (lands & blocked) | (ovr_flag & ~ovr_clear);
    end
  end

  assign dma_req = data_ready & dma_en & ~(hold_q & (perr_flag | ferr_flag | nerr_flag));

endmodule

module rx_err_dma_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic hold_q,
  input logic char_valid,
  input logic char_perr,
  input logic char_ferr,
  input logic char_nerr,
  input logic dma_en,
  input logic perr_clear,
  input logic ovr_clear,
  input logic data_ready,
  input logic perr_flag,
  input logic ferr_flag,
  input logic nerr_flag,
  input logic ovr_flag,
  input logic dma_req
);

  p_set_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && char_valid && char_perr) |=> perr_flag);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !perr_clear) |=> perr_flag);

  p_skip_faulty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && rx_en && char_valid && (char_perr || char_ferr || char_nerr) && !data_ready)
      |=> !data_ready);

  p_skip_no_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && rx_en && char_valid && (char_perr || char_ferr || char_nerr) && !ovr_flag)
      |=> !ovr_flag);

  p_hold_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && rx_en && char_valid) |=> data_ready);

  p_req_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (data_ready && dma_en));

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && (perr_flag || ferr_flag || nerr_flag)) |-> !dma_req);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clear) |=> ovr_flag);

  p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> $stable(hold_q));

endmodule

bind rx_err_dma_gate rx_err_dma_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .hold_q(hold_q),
  .char_valid(char_valid), .char_perr(char_perr), .char_ferr(char_ferr),
  .char_nerr(char_nerr), .dma_en(dma_en), .perr_clear(perr_clear),
  .ovr_clear(ovr_clear), .data_ready(data_ready), .perr_flag(perr_flag),
  .ferr_flag(ferr_flag), .nerr_flag(nerr_flag), .ovr_flag(ovr_flag),
  .dma_req(dma_req)
);

// File: tb/rx_err_dma_gate_test.sv
`timescale 1ns/1ps
module rx_err_dma_gate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, mode = 0, cv = 0, pe = 0, fe = 0, ne = 0, den = 0;
  logic drc = 0, pec = 0, fec = 0, nec = 0, ovc = 0;
  logic data_ready, perr_flag, ferr_flag, nerr_flag, ovr_flag, dma_req;

  int checks = 0, fails = 0;
  string phase = "R6";
  bit m_hold, m_dr, m_pe, m_fe, m_ne, m_ov;

  always #5 clk = ~clk;

  rx_err_dma_gate uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .err_hold_mode(mode),
    .char_valid(cv), .char_perr(pe), .char_ferr(fe), .char_nerr(ne),
    .dma_en(den), .dr_clear(drc), .perr_clear(pec), .ferr_clear(fec),
    .nerr_clear(nec), .ovr_clear(ovc), .data_ready(data_ready),
    .perr_flag(perr_flag), .ferr_flag(ferr_flag), .nerr_flag(nerr_flag),
    .ovr_flag(ovr_flag), .dma_req(dma_req));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic bit m_req();
    return m_dr && den && !(m_hold && (m_pe || m_fe || m_ne));
  endfunction

  task automatic compare();
    chk(phase, "data_ready", data_ready, m_dr);
    chk(phase, "perr_flag", perr_flag, m_pe);
    chk(phase, "ferr_flag", ferr_flag, m_fe);
    chk(phase, "nerr_flag", nerr_flag, m_ne);
    chk(phase, "ovr_flag", ovr_flag, m_ov);
    chk(phase, "dma_req", dma_req, m_req());
  endtask

  task automatic tick();
    bit acc, bad, lands, busy;
    @(posedge clk);
    acc = rx_en && cv;
    bad = pe || fe || ne;
    lands = acc && (m_hold || !bad);
    busy = m_dr && !drc;
    m_ov = (lands && busy) || (m_ov && !ovc);
    m_dr = lands || (m_dr && !drc);
    m_pe = (acc && pe) || (m_pe && !pec);
    m_fe = (acc && fe) || (m_fe && !fec);
    m_ne = (acc && ne) || (m_ne && !nec);
    if (!rx_en) m_hold = mode;
    #1;
    cv = 0; pe = 0; fe = 0; ne = 0; drc = 0; pec = 0; fec = 0; nec = 0; ovc = 0;
    #0 compare();
  endtask

  task automatic char_in(input logic p, input logic f, input logic n);
    cv = 1; pe = p; fe = f; ne = n;
    tick();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk("R6", "reset data_ready", data_ready, 1'b0);
    chk("R6", "reset dma_req", dma_req, 1'b0);
    #20 rst_n = 1;
    tick();

    phase = "R9";
    den = 1; mode = 0;
    char_in(1, 0, 0);
    chk("R9", "ignored char perr", perr_flag, 1'b0);
    chk("R9", "ignored char dr", data_ready, 1'b0);

    rx_en = 1;
    phase = "R3";
    char_in(1, 0, 0);
    chk("R3", "skip faulty dr", data_ready, 1'b0);
    chk("R1", "perr set", perr_flag, 1'b1);
    chk("R3", "skip faulty req", dma_req, 1'b0);
    phase = "R4";
    char_in(0, 0, 0);
    chk("R4", "clean dr", data_ready, 1'b1);
    chk("R4", "clean req", dma_req, 1'b1);
    phase = "R3";
    char_in(0, 1, 0);
    chk("R3", "faulty while held no ovr", ovr_flag, 1'b0);
    chk("R1", "ferr set", ferr_flag, 1'b1);
    phase = "R8";
    char_in(0, 0, 0);
    chk("R8", "overrun", ovr_flag, 1'b1);
    chk("R8", "dr kept", data_ready, 1'b1);
    phase = "R7";
    drc = 1; tick();
    chk("R7", "read clears dr", data_ready, 1'b0);
    chk("R2", "dr_clear keeps ferr", ferr_flag, 1'b1);
    phase = "R2";
    pec = 1; tick();
    chk("R2", "perr cleared", perr_flag, 1'b0);
    chk("R2", "ferr untouched", ferr_flag, 1'b1);
    chk("R2", "ovr untouched", ovr_flag, 1'b1);
    phase = "R1";
    fec = 1; char_in(0, 1, 0);
    chk("R1", "set wins over clear", ferr_flag, 1'b1);
    fec = 1; ovc = 1; char_in(0, 0, 1);
    chk("R1", "nerr set", nerr_flag, 1'b1);
    chk("R8", "ovr cleared", ovr_flag, 1'b0);
    nec = 1; tick();

    phase = "R9";
    rx_en = 0; mode = 1; tick();
    rx_en = 1; mode = 0; tick();
    phase = "R5";
    char_in(0, 0, 1);
    chk("R5", "hold dr", data_ready, 1'b1);
    chk("R5", "hold nerr", nerr_flag, 1'b1);
    chk("R9", "hold mode kept while enabled", dma_req, 1'b0);
    phase = "R10";
    nec = 1; tick();
    chk("R10", "req after clear", dma_req, 1'b1);
    phase = "R7";
    drc = 1; char_in(0, 0, 0);
    chk("R7", "read+arrive dr", data_ready, 1'b1);
    chk("R7", "read+arrive no ovr", ovr_flag, 1'b0);
    phase = "R6";
    den = 0; #1;
    chk("R6", "dma_en low", dma_req, 1'b0);
    den = 1; #1;
    chk("R6", "dma_en high", dma_req, 1'b1);

    phase = "R8";
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 499) rx_en = 0;
      else if (i % 500 == 2) rx_en = 1;
      if ($urandom_range(0, 49) == 0) mode = ~mode;
      den = ($urandom_range(0, 7) != 0);
      cv = $urandom_range(0, 2) == 0;
      pe = $urandom_range(0, 5) == 0;
      fe = $urandom_range(0, 5) == 0;
      ne = $urandom_range(0, 5) == 0;
      drc = $urandom_range(0, 2) == 0;
      pec = $urandom_range(0, 3) == 0;
      fec = $urandom_range(0, 3) == 0;
      nec = $urandom_range(0, 3) == 0;
      ovc = $urandom_range(0, 3) == 0;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule